// File: doc/BRIEF.md
# Clock-Enable Rule Monitor for a Multi-Pass Transform Engine

This block watches the clock-enable input of a multi-pass transform engine alongside the engine's pass status. It reports any use of clock enable that the engine cannot tolerate. The block only observes. It never drives clock enable and never stalls the engine.

Three rules are enforced:

- Clock enable must stay high from a start pulse until the first input sample has been taken.
- Clock enable may drop only while a load pass or an unload pass is under way.
- Every low excursion of clock enable must last at least a minimum number of cycles.

The first rule broken is captured in a sticky flag and a code register. Both hold until reset, so a system controller or a simulation harness can read a single verdict per run.

Integration is simple. Tap the clock-enable net, the start pulse and the first-sample strobe. Then connect the three pass indicators. The load and unload indicators are the ones in which gating is allowed.

Top module: `cke_rule_monitor`

## Requirements
- R1: While reset is sampled high, the next edge clears viol_flag to 0 and viol_code to 2'b00. A violation that was already captured is cleared as well.
- R2: Code 2'b01 (early drop) is captured when clock enable is sampled low in a cycle that lies inside the early window. That window opens in the cycle start is high and closes after the cycle first_sample_ok is high, both ends included.
- R3: Clock enable sampled low while in_load or in_unload is high is permitted. If each low run lasts at least MIN_LOW cycles, nothing is reported.
- R4: Code 2'b10 (middle-pass drop) is captured when clock enable is sampled low while in_middle is high and neither in_load nor in_unload is high.
- R5: Code 2'b11 (short low) is captured in the cycle clock enable returns high after a low run of 1 to MIN_LOW-1 cycles. A run of exactly MIN_LOW cycles is not reported.
- R6: Only the first violation is captured. Once viol_flag is 1, neither flag nor code changes until reset.
- R7: When several rules break in the same cycle, the captured code follows the priority early drop, then middle-pass drop, then short low.
- R8: A low run still in progress when reset is sampled is forgotten. Clock enable returning high after reset produces no short-low report.
- R9: A transform with only load and unload passes, where in_middle is never high, can gate clock enable in both passes without any report.
- R10: viol_flag and viol_code are registered. They change at the clock edge that samples the offending input values, and viol_flag is 1 exactly when viol_code is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| reset | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Observed clock enable of the engine |
| start | input | 1 | One-cycle start pulse of a transform |
| first_sample_ok | input | 1 | Strobe: first input sample taken by the engine |
| in_load | input | 1 | Engine is in its load (first) pass |
| in_middle | input | 1 | Engine is in an intermediate pass |
| in_unload | input | 1 | Engine is in its unload (last) pass |
| viol_flag | output | 1 | Sticky: a rule has been broken since reset |
| viol_code | output | 2 | Rule broken first: 00 none, 01 early, 10 middle, 11 short |

## Verification
The bench builds the monitor with its default MIN_LOW of 4 and a 3-bit run counter. This lets it try low runs of 3, 4 and 5 cycles, covering both sides of the short-low boundary and the saturation of the counter. A behavioural model steps in lockstep with the monitor. The bench drives it through several scenarios:

- early drops, including one in the start cycle that collides with a middle-pass drop;
- middle-pass drops, including one where middle and load indicators overlap;
- short runs and a run interrupted by reset;
- a two-pass transform with two legal gated runs.

// File: rtl/cke_rule_pkg.sv
package cke_rule_pkg;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    VC_NONE   = 2'b00,
    VC_EARLY  = 2'b01,
    VC_MIDDLE = 2'b10,
    VC_SHORT  = 2'b11
  } viol_code_t;
endpackage

// File: rtl/cke_window_check.sv
// Tracks the start-to-first-sample window and decodes the pass-based rules.
module cke_window_check (
  input  logic clk,
  input  logic reset,
  input  logic cke,
  input  logic start,
  input  logic first_sample_ok,
  input  logic in_load,
  input  logic in_middle,
  input  logic in_unload,
  output logic early_hit,
  output logic middle_hit
);
  logic awaiting_q;
  logic in_window;
  logic gate_allowed;

  // Window includes the start cycle and the first-sample cycle.
  assign in_window    = start | awaiting_q;
  assign gate_allowed = in_load | in_unload;

  always_ff @(posedge clk) begin
    if (reset)                awaiting_q <= 1'b0;
    else if (start)           awaiting_q <= 1'b1;
    else if (first_sample_ok) awaiting_q <= 1'b0;
  end

  always_comb begin
    early_hit  = ~cke & in_window;
    middle_hit = ~cke & in_middle & ~gate_allowed;
  end
endmodule

// File: rtl/cke_low_run.sv
// Counts consecutive low cycles of clock enable and reports runs that end too soon.
module cke_low_run #(
  parameter int MIN_LOW = 4
) (
  input  logic clk,
  input  logic reset,
  input  logic cke,
  output logic short_hit
);
  localparam int CNT_W = $clog2(MIN_LOW + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW);

  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (reset || cke)        run_q <= '0;
    else if (run_q != CNT_MAX) run_q <= run_q + 1'b1;
  end

  assign short_hit = cke && (run_q != '0) && (run_q < CNT_MAX);
endmodule

// File: rtl/cke_viol_latch.sv
// Captures the first violation with fixed priority and holds it until reset.
module cke_viol_latch
  import cke_rule_pkg::*;
(
  input  logic              clk,
  input  logic              reset,
  input  logic              early_hit,
  input  logic              middle_hit,
  input  logic              short_hit,
  output logic              viol_flag,
  output logic [CODE_W-1:0] viol_code
);
  viol_code_t pick;

  always_comb begin
    if (early_hit)       pick = VC_EARLY;
    else if (middle_hit) pick = VC_MIDDLE;
    else if (short_hit)  pick = VC_SHORT;
    else                 pick = VC_NONE;
  end

  always_ff @(posedge clk) begin
    if (reset) begin
      viol_flag <= 1'b0;
      viol_code <= VC_NONE;
    end else if (!viol_flag && pick != VC_NONE) begin
      viol_flag <= 1'b1;
      viol_code <= pick;
    end
  end
endmodule

// File: rtl/cke_rule_monitor.sv
module cke_rule_monitor #(
  parameter int MIN_LOW = 4
) (
  input  logic       clk,
  input  logic       reset,
  input  logic       cke,
  input  logic       start,
  input  logic       first_sample_ok,
  input  logic       in_load,
  input  logic       in_middle,
  input  logic       in_unload,
  output logic       viol_flag,
  output logic [1:0] viol_code
);
  logic early_hit;
  logic middle_hit;
  logic short_hit;

  cke_window_check u_window (
    .clk             (clk),
    .reset           (reset),
    .cke             (cke),
    .start           (start),
    .first_sample_ok (first_sample_ok),
    .in_load         (in_load),
    .in_middle       (in_middle),
    .in_unload       (in_unload),
    .early_hit       (early_hit),
    .middle_hit      (middle_hit)
  );

  cke_low_run #(.MIN_LOW(MIN_LOW)) u_run (
    .clk       (clk),
    .reset     (reset),
    .cke       (cke),
    .short_hit (short_hit)
  );

  cke_viol_latch u_latch (
    .clk        (clk),
    .reset      (reset),
    .early_hit  (early_hit),
    .middle_hit (middle_hit),
    .short_hit  (short_hit),
    .viol_flag  (viol_flag),
    .viol_code  (viol_code)
  );
endmodule

// File: rtl/cke_rule_monitor_chk.sv
module cke_rule_monitor_chk (
  input logic       clk,
  input logic       reset,
  input logic       cke,
  input logic       start,
  input logic       in_load,
  input logic       in_middle,
  input logic       in_unload,
  input logic       viol_flag,
  input logic [1:0] viol_code
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= reset;

  always_ff @(posedge clk) begin
    if (rst_q) AST_RESET_CLEARS: assert (!viol_flag && viol_code == 2'b00); // R1
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (reset)
    viol_flag |=> viol_flag); // R6
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (reset)
    viol_flag |=> $stable(viol_code)); // R6
  AST_EARLY_START: assert property (@(posedge clk) disable iff (reset)
    (start && !cke && !viol_flag) |=> (viol_flag && viol_code == 2'b01)); // R2
  AST_MIDDLE_LOW: assert property (@(posedge clk) disable iff (reset)
    (!cke && in_middle && !in_load && !in_unload && !viol_flag) |=> viol_flag); // R4
  AST_FLAG_MATCHES_CODE: assert property (@(posedge clk) disable iff (reset)
    viol_flag == (viol_code != 2'b00)); // R10
endmodule

bind cke_rule_monitor cke_rule_monitor_chk u_chk (
  .clk       (clk),
  .reset     (reset),
  .cke       (cke),
  .start     (start),
  .in_load   (in_load),
  .in_middle (in_middle),
  .in_unload (in_unload),
  .viol_flag (viol_flag),
  .viol_code (viol_code)
);

// File: tb/cke_rule_monitor_tb.sv
module cke_rule_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_LOW    = 4;

  logic clk = 1'b0;
  logic reset = 1'b1;
  logic cke = 1'b1;
  logic start = 1'b0;
  logic first_sample_ok = 1'b0;
  logic in_load = 1'b0;
  logic in_middle = 1'b0;
  logic in_unload = 1'b0;
  logic viol_flag;
  logic [1:0] viol_code;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";

  // Behavioural reference state.
  bit m_flag = 0;
  int m_code = 0;
  int m_run = 0;
  bit m_wait = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cke_rule_monitor #(.MIN_LOW(MIN_LOW)) u_dut (
    .clk(clk), .reset(reset), .cke(cke), .start(start),
    .first_sample_ok(first_sample_ok), .in_load(in_load),
    .in_middle(in_middle), .in_unload(in_unload),
    .viol_flag(viol_flag), .viol_code(viol_code)
  );

  always @(posedge clk) begin
    bit e, p, s;
    if (reset) begin
      m_flag = 0; m_code = 0; m_run = 0; m_wait = 0;
    end else begin
      e = !cke && (start || m_wait);
      p = !cke && in_middle && !in_load && !in_unload;
      s = cke && m_run > 0 && m_run < MIN_LOW;
      if (!m_flag && (e || p || s)) begin
        m_flag = 1;
        m_code = e ? 1 : (p ? 2 : 3);
      end
      if (cke) m_run = 0;
      else if (m_run < MIN_LOW) m_run++;
      if (start) m_wait = 1;
      else if (first_sample_ok) m_wait = 0;
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compared++;
    if (viol_flag !== m_flag || viol_code !== 2'(m_code)) begin
      mismatched++;
      $display("FAIL %s: flag=%0b code=%0d expected flag=%0b code=%0d at %0t",
               cur_req, viol_flag, viol_code, m_flag, m_code, $time);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_reset();
    reset = 1; cke = 1; start = 0; first_sample_ok = 0;
    in_load = 0; in_middle = 0; in_unload = 0;
    ticks(2);
    reset = 0;
  endtask

  // Exact check of the captured code, tagged with the requirement.
  task automatic expect_code(int c, string req);
    compared++;
    if (viol_code !== 2'(c) || viol_flag !== (c != 0)) begin
      mismatched++;
      $display("FAIL %s: code=%0d flag=%0b expected code=%0d", req, viol_code, viol_flag, c);
    end
  endtask

  task automatic low_run(int n);
    cke = 0; ticks(n); cke = 1; tick();
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    do_reset(); tick();
    expect_code(0, "R1");

    // R2: early drop after start, before first sample
    cur_req = "R2";
    start = 1; tick(); start = 0; ticks(2);
    cke = 0; ticks(MIN_LOW); cke = 1; tick();
    expect_code(1, "R2");
    // R1: reset clears a captured code
    cur_req = "R1";
    do_reset(); tick();
    expect_code(0, "R1");

    // R3: legal gating in load after first sample, run of exactly MIN_LOW
    cur_req = "R3";
    start = 1; tick(); start = 0; in_load = 1; ticks(2);
    first_sample_ok = 1; tick(); first_sample_ok = 0;
    low_run(MIN_LOW); ticks(2);
    expect_code(0, "R3");
    low_run(MIN_LOW + 1);
    expect_code(0, "R3");

    // R4: overlap of middle and load is permitted, then middle-only drop
    cur_req = "R4";
    in_middle = 1; low_run(MIN_LOW);
    expect_code(0, "R4");
    in_load = 0; cke = 0; tick();
    expect_code(2, "R4");
    // R6: a later short-low end does not overwrite
    cur_req = "R6";
    cke = 1; tick(); in_middle = 0; in_unload = 1; ticks(3);
    expect_code(2, "R6");

    // R5: short run of MIN_LOW-1 in unload
    cur_req = "R5";
    do_reset(); in_unload = 1; tick();
    low_run(MIN_LOW - 1);
    expect_code(3, "R5");
    // R5: single-cycle run
    do_reset(); in_unload = 1;
    low_run(1);
    expect_code(3, "R5");

    // R8: run interrupted by reset is forgotten
    cur_req = "R8";
    do_reset(); in_load = 1;
    cke = 0; ticks(2);
    reset = 1; tick(); reset = 0;
    cke = 1; ticks(3);
    expect_code(0, "R8");

    // R9: two-pass transform with gating in both passes
    cur_req = "R9";
    do_reset();
    start = 1; tick(); start = 0; in_load = 1;
    first_sample_ok = 1; tick(); first_sample_ok = 0;
    low_run(MIN_LOW + 1); in_load = 0; in_unload = 1; tick();
    low_run(MIN_LOW); ticks(2);
    expect_code(0, "R9");

    // R7: early and middle drop in the same cycle, early wins
    cur_req = "R7";
    do_reset(); in_middle = 1;
    cke = 0; start = 1; tick(); start = 0; cke = 1; tick();
    expect_code(1, "R7");
    // R7: middle and short in same cycle impossible (cke differs); middle beats later short
    do_reset(); in_load = 1; cke = 0; tick();
    in_load = 0; in_middle = 1; tick(); cke = 1; tick();
    expect_code(2, "R7");

    // R10: capture visible one edge after the offending sample
    cur_req = "R10";
    do_reset(); in_middle = 1; tick();
    expect_code(0, "R10");
    cke = 0; tick(); cke = 1;
    expect_code(2, "R10");
    ticks(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule